// File: doc/BRIEF.md
# Posted Write Buffer with Fetch Invalidation

This block sits between a host processor bus and one arbitrated port into an external shared memory. A host write to the memory window is parked in an eight-entry queue of address/data pairs and completes at once. The queue is written out to memory in arrival order, one entry per memory transaction. The host waits only when the queue is completely full.

A small fully associative fetch store keeps the words the host read recently. A read that hits in the store completes in the same cycle. A read that misses holds the host until every queued write has reached memory. The word is then read, placed in the store and returned. Any accepted write to an address held in the store removes that entry, so a later read cannot return stale data. Only accesses qualified by the memory-window select use the buffer.

Top module: `posted_wbuf`

## Requirements
- R1: The queue holds up to 8 entries, each an address and a data word. Queued writes reach memory in the order the host issued them, with the address and data unchanged.
- R2: A memory-window write while fewer than 8 entries are queued completes with `host_wait` low in the same cycle.
- R3: A memory-window write while all 8 entries are occupied raises `host_wait` and is not taken. It is taken, and its data is kept, once an entry frees.
- R4: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until a cycle in which `mem_gnt` is high. The head queue entry is not released until `mem_ack` is seen for its write.
- R5: A read whose address is valid in the fetch store returns the stored word with `host_wait` low in the same cycle.
- R6: A read miss holds `host_wait` high. No memory read (`mem_we` low) is requested while any write is queued. The word returned with `mem_ack` is loaded into the store and returned to the host.
- R7: An accepted write to an address held in the fetch store invalidates that entry, so the next read of that address misses.
- R8: After reset the queue is empty, `mem_req` is low and no fetch entry is valid, so the first read of any address misses.
- R9: The fetch store has 4 entries replaced in round-robin order from entry 0 after reset. After 5 distinct read misses, the first address read is evicted and the other four still hit.
- R10: If a fill and an invalidating write target the same address in the same cycle, the invalidate wins and that address is not valid afterwards.
- R11: With `host_msel` low, reads and writes are ignored: `host_wait` stays low, nothing is queued and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_msel | input | 1 | Memory-window select from the host decode |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data to host |
| host_wait | output | 1 | Host must hold the current access |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | ADDR_W | Transaction address |
| mem_wdata | output | DATA_W | Transaction write data |
| mem_gnt | input | 1 | Memory port accepted the request |
| mem_ack | input | 1 | Transaction completed; read data valid |
| mem_rdata | input | DATA_W | Read data from memory |

## Verification
A wrong queue pointer shows up at the memory port within one drain. A write goes missing, repeats or lands out of order, or `host_wait` rises one write too early or too late. A stale or wrongly valid fetch tag shows up on the next read of that address: a hit returns old data with no wait, or a miss makes the host wait. A broken replacement pointer shows up only after the fifth distinct fill, as the wrong address evicted.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

   typedef enum logic [1:0] {
      MP_IDLE,
      MP_REQ,
      MP_WAIT_ACK
   } mport_state_e;

   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [ADDR_W-1:0] push_addr_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [ADDR_W-1:0] head_addr_o,
   output logic [DATA_W-1:0] head_data_o,
   output logic              full_o,
   output logic              empty_o
);
   import wbuf_pkg::*;

   localparam int IW = $clog2(DEPTH);
   localparam int PW = IW + 1;

   generate
      if (!is_pow2(DEPTH)) begin : g_bad_depth
         $error("wbuf_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [PW-1:0]     wp_q, rp_q;
   logic [ADDR_W-1:0] addr_mem [DEPTH];
   logic [DATA_W-1:0] data_mem [DEPTH];

   assign full_o  = (wp_q[IW] != rp_q[IW]) && (wp_q[IW-1:0] == rp_q[IW-1:0]);
   assign empty_o = (wp_q == rp_q);

   assign head_addr_o = addr_mem[rp_q[IW-1:0]];
   assign head_data_o = data_mem[rp_q[IW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push_i && !full_o) wp_q <= wp_q + PW'(1);
         if (pop_i && !empty_o) rp_q <= rp_q + PW'(1);
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (push_i && !full_o && (wp_q[IW-1:0] == IW'(i))) begin
               addr_mem[i] <= push_addr_i;
               data_mem[i] <= push_data_i;
            end
         end
      end
   endgenerate

   assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !pop_i) |=> full_o);

   assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);

endmodule

// File: rtl/wbuf_fetch.sv
module wbuf_fetch #(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr_i,
   output logic              hit_o,
   output logic [DATA_W-1:0] hit_data_o,
   input  logic              fill_i,
   input  logic [ADDR_W-1:0] fill_addr_i,
   input  logic [DATA_W-1:0] fill_data_i,
   input  logic              inv_i,
   input  logic [ADDR_W-1:0] inv_addr_i
);
   import wbuf_pkg::*;

   localparam int EW = $clog2(ENTRIES);

   generate
      if (!is_pow2(ENTRIES)) begin : g_bad_entries
         $error("wbuf_fetch: ENTRIES must be a power of two of at least 2");
      end
   endgenerate

   logic [ENTRIES-1:0] valid_q;
   logic [ADDR_W-1:0]  tag_q  [ENTRIES];
   logic [DATA_W-1:0]  data_q [ENTRIES];
   logic [ENTRIES-1:0] match;
   logic [EW-1:0]      rr_q;
   logic               fill_killed;

   assign fill_killed = fill_i && inv_i && (fill_addr_i == inv_addr_i);

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
         assign match[i] = valid_q[i] && (tag_q[i] == lk_addr_i);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_q[i] <= 1'b0;
            end else if (fill_i && (rr_q == EW'(i))) begin
               tag_q[i]   <= fill_addr_i;
               data_q[i]  <= fill_data_i;
               valid_q[i] <= !fill_killed;
            end else if (inv_i && valid_q[i] && (tag_q[i] == inv_addr_i)) begin
               valid_q[i] <= 1'b0;
            end
         end
      end
   endgenerate

   assign hit_o = |match;

   always_comb begin
      hit_data_o = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) hit_data_o = hit_data_o | data_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rr_q <= '0;
      else if (fill_i) rr_q <= rr_q + EW'(1);
   end

   function automatic logic held(input logic [ADDR_W-1:0] a);
      logic r;
      r = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (valid_q[i] && (tag_q[i] == a)) r = 1'b1;
      end
      return r;
   endfunction

   assert_inv_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inv_i |=> !held($past(inv_addr_i)));

   assert_inv_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_i && inv_i && (fill_addr_i == inv_addr_i)) |=> !held($past(fill_addr_i)));

   assert_one_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

endmodule

// File: rtl/posted_wbuf.sv
module posted_wbuf #(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 16,
   parameter int FIFO_DEPTH    = 8,
   parameter int FETCH_ENTRIES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_msel,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_wait,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   import wbuf_pkg::*;

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("posted_wbuf: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic              wr_try, rd_try, push, pop, fill;
   logic              q_full, q_empty, hit;
   logic [ADDR_W-1:0] head_addr;
   logic [DATA_W-1:0] head_data, hit_data;

   mport_state_e      st_q;
   logic              cur_we_q;
   logic [ADDR_W-1:0] cur_addr_q;
   logic [DATA_W-1:0] cur_data_q;

   assign wr_try = host_msel && host_wr;
   assign rd_try = host_msel && host_rd && !host_wr;
   assign push   = wr_try && !q_full;

   wbuf_fifo #(
      .DEPTH  (FIFO_DEPTH),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .push_addr_i (host_addr),
      .push_data_i (host_wdata),
      .pop_i       (pop),
      .head_addr_o (head_addr),
      .head_data_o (head_data),
      .full_o      (q_full),
      .empty_o     (q_empty)
   );

   wbuf_fetch #(
      .ENTRIES (FETCH_ENTRIES),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .lk_addr_i   (host_addr),
      .hit_o       (hit),
      .hit_data_o  (hit_data),
      .fill_i      (fill),
      .fill_addr_i (cur_addr_q),
      .fill_data_i (mem_rdata),
      .inv_i       (push),
      .inv_addr_i  (host_addr)
   );

   assign host_rdata = hit_data;
   assign host_wait  = (wr_try && q_full) || (rd_try && !hit);

   assign pop  = (st_q == MP_WAIT_ACK) && mem_ack && cur_we_q;
   assign fill = (st_q == MP_WAIT_ACK) && mem_ack && !cur_we_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= MP_IDLE;
         cur_we_q   <= 1'b0;
         cur_addr_q <= '0;
         cur_data_q <= '0;
      end else begin
         unique case (st_q)
            MP_IDLE: begin
               if (!q_empty) begin
                  cur_we_q   <= 1'b1;
                  cur_addr_q <= head_addr;
                  cur_data_q <= head_data;
                  st_q       <= MP_REQ;
               end else if (rd_try && !hit) begin
                  cur_we_q   <= 1'b0;
                  cur_addr_q <= host_addr;
                  st_q       <= MP_REQ;
               end
            end
            MP_REQ: begin
               if (mem_gnt) st_q <= MP_WAIT_ACK;
            end
            MP_WAIT_ACK: begin
               if (mem_ack) st_q <= MP_IDLE;
            end
            default: st_q <= MP_IDLE;
         endcase
      end
   end

   assign mem_req   = (st_q == MP_REQ);
   assign mem_we    = cur_we_q;
   assign mem_addr  = cur_addr_q;
   assign mem_wdata = cur_data_q;

   assert_req_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

   assert_head_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == MP_WAIT_ACK) && cur_we_q && !mem_ack) |=> $stable(head_addr));

   assert_read_after_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> q_empty);

   assert_no_wait_unselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !host_msel |-> !host_wait);

   assert_write_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_try && !q_full) |-> !host_wait);

endmodule

// File: tb/posted_wbuf_tb.sv
module posted_wbuf_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_msel = 0, host_wr = 0, host_rd = 0;
   logic [15:0] host_addr = 0, host_wdata = 0;
   logic [15:0] host_rdata;
   logic        host_wait;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr, mem_wdata;
   logic        mem_gnt = 0, mem_ack = 0;
   logic [15:0] mem_rdata = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   posted_wbuf u_dut (
      .clk(clk), .rst_n(rst_n), .host_msel(host_msel), .host_wr(host_wr),
      .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_wait(host_wait), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int checks = 0, fails = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model, acting on falling edges
   logic [15:0] mem [256];
   logic [15:0] log_a [64];
   logic        log_w [64];
   logic [15:0] log_d [64];
   int          log_n = 0;
   bit          block = 0, manual = 0, ack_release = 0;
   int          gnt_delay = 1, ack_delay = 2;
   int          ms = 0, cnt = 0;
   logic        lat_we;
   logic [15:0] lat_a, lat_d;

   function automatic logic [15:0] init_val(input logic [15:0] a);
      return 16'hA500 ^ {8'h00, a[7:0]};
   endfunction

   initial for (int i = 0; i < 256; i++) mem[i] = init_val(16'(i));

   always @(negedge clk) begin
      mem_gnt = 0;
      mem_ack = 0;
      if (!rst_n) begin
         ms = 0; cnt = 0;
      end else if (ms == 0) begin
         if (mem_req && !block) begin
            if (cnt >= gnt_delay) begin
               mem_gnt = 1; lat_we = mem_we; lat_a = mem_addr; lat_d = mem_wdata;
               cnt = 0; ms = 1;
            end else cnt++;
         end
      end else begin
         if (manual ? ack_release : (cnt >= ack_delay)) begin
            mem_ack = 1;
            if (lat_we) mem[lat_a[7:0]] = lat_d;
            else        mem_rdata = mem[lat_a[7:0]];
            if (log_n < 64) begin
               log_a[log_n] = lat_a; log_w[log_n] = lat_we; log_d[log_n] = lat_d;
               log_n++;
            end
            ms = 0; cnt = 0;
         end else cnt++;
      end
   end

   // host tasks: start just after a falling edge, end at a later falling edge
   task automatic hwrite(input logic [15:0] a, input logic [15:0] d, output int waits);
      host_msel = 1; host_wr = 1; host_rd = 0; host_addr = a; host_wdata = d;
      waits = 0;
      #1;
      while (host_wait) begin @(negedge clk); #1; waits++; end
      @(negedge clk); #1;
      host_wr = 0; host_msel = 0;
   endtask

   task automatic hread(input logic [15:0] a, output logic [15:0] d, output int waits);
      host_msel = 1; host_rd = 1; host_wr = 0; host_addr = a;
      waits = 0;
      #1;
      while (host_wait) begin @(negedge clk); #1; waits++; end
      d = host_rdata;
      @(negedge clk); #1;
      host_rd = 0; host_msel = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); #1;
      rst_n = 0;
      repeat (2) @(negedge clk);
      #1 rst_n = 1;
   endtask

   task automatic wait_log(input int n);
      int t;
      t = 0;
      while (log_n < n && t < 200) begin @(negedge clk); t++; end
      #1;
   endtask

   typedef struct packed {
      logic        is_wr;
      logic [15:0] a;
      logic [15:0] d;
      logic        exp_hit;
   } vec_t;

   localparam vec_t VECS [11] = '{
      '{1'b1, 16'h0010, 16'h1111, 1'b0},
      '{1'b1, 16'h0011, 16'h2222, 1'b0},
      '{1'b0, 16'h0010, 16'h0000, 1'b0},
      '{1'b0, 16'h0010, 16'h0000, 1'b1},
      '{1'b0, 16'h0011, 16'h0000, 1'b0},
      '{1'b1, 16'h0010, 16'h3333, 1'b0},
      '{1'b0, 16'h0010, 16'h0000, 1'b0},
      '{1'b0, 16'h0010, 16'h0000, 1'b1},
      '{1'b0, 16'h0011, 16'h0000, 1'b1},
      '{1'b0, 16'h0020, 16'h0000, 1'b0},
      '{1'b0, 16'h0020, 16'h0000, 1'b1}
   };

   initial begin
      logic [15:0] shadow [256];
      logic [15:0] rd;
      int          w, base;
      for (int i = 0; i < 256; i++) shadow[i] = init_val(16'(i));

      // R8: reset state
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      @(negedge clk); #1;
      chk(mem_req == 0, "R8 mem_req idle", 32'(mem_req), 0);
      chk(host_wait == 0, "R8 wait idle", 32'(host_wait), 0);
      host_msel = 1; host_rd = 1; host_addr = 16'h0030; #1;
      chk(host_wait == 1, "R8 first read misses", 32'(host_wait), 1);
      host_rd = 0; host_msel = 0;
      @(negedge clk); #1;

      // table walk: R2, R5, R6, R7
      for (int k = 0; k < 11; k++) begin
         if (VECS[k].is_wr) begin
            hwrite(VECS[k].a, VECS[k].d, w);
            shadow[VECS[k].a[7:0]] = VECS[k].d;
            chk(w == 0, "R2 write no wait", 32'(w), 0);
         end else begin
            hread(VECS[k].a, rd, w);
            chk(rd == shadow[VECS[k].a[7:0]], VECS[k].exp_hit ? "R5 hit data" : "R6 R7 miss data",
                32'(rd), 32'(shadow[VECS[k].a[7:0]]));
            chk((w == 0) == VECS[k].exp_hit, VECS[k].exp_hit ? "R5 hit no wait" : "R7 R6 miss waits",
                32'(w), 32'(!VECS[k].exp_hit));
         end
      end

      // R3, R4, R1: fill queue while memory is blocked
      block = 1;
      base = log_n;
      for (int k = 0; k < 8; k++) begin
         hwrite(16'h0040 + 16'(k), 16'h5000 + 16'(k), w);
         chk(w == 0, "R2 write into free slot", 32'(w), 0);
      end
      host_msel = 1; host_wr = 1; host_addr = 16'h0048; host_wdata = 16'h5008; #1;
      chk(host_wait == 1, "R3 wait when full", 32'(host_wait), 1);
      repeat (3) @(negedge clk);
      #1;
      chk(host_wait == 1, "R3 wait held", 32'(host_wait), 1);
      chk(mem_req == 1 && mem_addr == 16'h0040, "R4 head request held",
          32'({mem_req, mem_addr}), 32'({1'b1, 16'h0040}));
      block = 0;
      while (host_wait) begin @(negedge clk); #1; end
      @(negedge clk); #1;
      host_wr = 0; host_msel = 0;
      wait_log(base + 9);
      for (int k = 0; k < 9; k++) begin
         chk(log_w[base+k] && log_a[base+k] == 16'h0040 + 16'(k) && log_d[base+k] == 16'h5000 + 16'(k),
             "R1 drain order", 32'({log_a[base+k], log_d[base+k]}),
             32'({16'h0040 + 16'(k), 16'h5000 + 16'(k)}));
      end

      // R6: read miss must wait for queued writes
      block = 1;
      base = log_n;
      hwrite(16'h0050, 16'h6000, w);
      hwrite(16'h0051, 16'h6001, w);
      fork
         hread(16'h0050, rd, w);
         begin
            repeat (4) @(negedge clk);
            #2;
            chk(mem_req && mem_we, "R6 no read while writes queued", 32'({mem_req, mem_we}), 3);
            block = 0;
         end
      join
      chk(rd == 16'h6000, "R6 miss returns drained data", 32'(rd), 32'(16'h6000));
      chk(log_n == base + 3 && !log_w[base+2], "R6 read after writes",
          32'(log_n - base), 3);

      // R11: unselected access ignored
      base = log_n;
      @(negedge clk); #1;
      host_msel = 0; host_wr = 1; host_addr = 16'h0051; host_wdata = 16'hDEAD; #1;
      chk(host_wait == 0, "R11 no wait unselected", 32'(host_wait), 0);
      @(negedge clk); #1;
      host_wr = 0;
      repeat (6) @(negedge clk);
      #1;
      chk(log_n == base && mem_req == 0, "R11 no memory traffic", 32'(log_n - base), 0);
      hread(16'h0051, rd, w);
      chk(rd == 16'h6001, "R11 write discarded", 32'(rd), 32'(16'h6001));

      // R9: round-robin replacement after reset
      do_reset();
      @(negedge clk); #1;
      for (int k = 0; k < 4; k++) begin
         hread(16'h0060 + 16'(k), rd, w);
         chk(w > 0, "R8 R9 fill miss", 32'(w), 1);
      end
      for (int k = 0; k < 4; k++) begin
         hread(16'h0060 + 16'(k), rd, w);
         chk(w == 0 && rd == init_val(16'h0060 + 16'(k)), "R9 four entries hit",
             32'(w), 0);
      end
      hread(16'h0064, rd, w);
      hread(16'h0061, rd, w);
      chk(w == 0, "R9 survivor hits", 32'(w), 0);
      hread(16'h0060, rd, w);
      chk(w > 0, "R9 oldest evicted", 32'(w), 1);

      // R10: fill and invalidate to the same address in one cycle
      manual = 1; ack_release = 0;
      @(negedge clk); #1;
      host_msel = 1; host_rd = 1; host_addr = 16'h0070;
      repeat (4) @(negedge clk);
      #2 ack_release = 1;
      @(negedge clk); #1;
      host_rd = 0; host_wr = 1; host_wdata = 16'h7777;
      @(negedge clk); #1;
      host_wr = 0; host_msel = 0; ack_release = 0; manual = 0;
      hread(16'h0070, rd, w);
      chk(w > 0, "R10 invalidate wins", 32'(w), 1);
      chk(rd == 16'h7777, "R10 newer write returned", 32'(rd), 32'(16'h7777));

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule